// File: doc/BRIEF.md
# Timer Output-Compare Channel with Period Trigger

The block watches a free-running timer and acts when it reaches a programmed value. Software loads a compare value and a 4-bit action code through two plain write strobes. A select input picks one of two timer counts. On every cycle the block compares the compare value with the full width of the selected count. The first cycle on which they agree is a match event, and the active code then decides what the event does. It can drive the output latch high or low, invert it, or only raise the sticky interrupt flag. The last option is the period trigger: a one-cycle pulse that tells the selected timer to restart at zero and can also start an A/D conversion.

The timer counters and the converter are outside the block. A timer restarted by the pulse keeps its own overflow flag untouched, because the pulse is a separate reset line. All pins are plain control and status signals with no handshakes. A write strobe is accepted on the cycle it is high, and the result is used from the next cycle.

Top module: `ocmp_channel`

## Requirements
- R1: During and right after reset, pin_out, irq_flag, tmr_rst and adc_start are all 0, the action code is 4'b0000 and the compare value is 0.
- R2: A match exists when all bits of the compare value equal the selected count. tmr_sel=0 selects tmr_cnt[15:0] and tmr_sel=1 selects tmr_cnt[31:16]. A difference in any single bit, or a match on the unselected timer, is not a match. A value written with cmp_we is used from the next cycle.
- R3: With code 4'b1000, a match event sets the output latch to 1.
- R4: With code 4'b1001, a match event clears the output latch to 0.
- R5: With code 4'b0010, a match event inverts the output latch.
- R6: With code 4'b1010, a match event leaves the output latch unchanged.
- R7: The codes 4'b1000, 4'b1001, 4'b0010, 4'b1010 and 4'b1011 are active, and in each of them a match event sets irq_flag. irq_flag holds until irq_clr is high. A set and a clear on the same cycle leave it at 1. All other codes cause no action and no flag.
- R8: With code 4'b1011, a match event gives a one-cycle pulse on tmr_rst[tmr_sel] only and leaves the output latch unchanged.
- R9: adc_start pulses together with the code 4'b1011 pulse when adc_en was high on the match cycle. Otherwise it stays 0.
- R10: An action happens only on a cycle where a match is present and was absent on the cycle before. A count that stays on the compare value does not repeat the action.
- R11: Writing code 4'b0000 forces the output latch to 0 on the next cycle, even if a match event happens on the same cycle.
- R12: pin_oe equals pin_dir. pin_out equals the output latch while pin_dir is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Load strobe for the compare value |
| cmp_wdata | input | 16 | Compare value to load |
| mode_we | input | 1 | Load strobe for the action code |
| mode_wdata | input | 4 | Action code to load |
| tmr_sel | input | 1 | Timer select, 0 = lower count, 1 = upper count |
| tmr_cnt | input | 32 | Both timer counts, timer 0 in bits 15:0 |
| adc_en | input | 1 | Converter enabled, lets the trigger start a conversion |
| irq_clr | input | 1 | Clears the interrupt flag |
| pin_dir | input | 1 | Output-enable for the pin |
| tmr_rst | output | 2 | One-cycle restart pulse, one bit per timer |
| adc_start | output | 1 | One-cycle conversion start pulse |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| pin_out | output | 1 | Pin data, 0 while not enabled |
| pin_oe | output | 1 | Pin output enable |

## Verification
The match is decided combinationally from the registered compare value, the registered code and the live count. Its latch, flag and pulse results then appear one clock edge later. The exception is pin_out and pin_oe, which follow pin_dir within the same cycle. The bench drives each cycle's inputs at the falling edge and updates a requirement-level model from those inputs. It then samples every output just after the next rising edge, so each compare sees the result due exactly one edge after its stimulus. A write strobe is folded into the model only after that cycle's action has been worked out, which mirrors the one-cycle delay before a written value takes effect.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_OFF    = 4'b0000,
    M_TOGGLE = 4'b0010,
    M_SET    = 4'b1000,
    M_CLR    = 4'b1001,
    M_SWI    = 4'b1010,
    M_EVT    = 4'b1011
  } mode_e;

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    case (m)
      M_TOGGLE, M_SET, M_CLR, M_SWI, M_EVT: mode_active = 1'b1;
      default:                              mode_active = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ocmp_detect.sv
module ocmp_detect #(
  parameter int TW   = 16,
  parameter int NTMR = 2,
  localparam int SW  = $clog2(NTMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_we,
  input  logic [TW-1:0]      cmp_wdata,
  input  logic [SW-1:0]      tmr_sel,
  input  logic [NTMR*TW-1:0] tmr_cnt,
  output logic               match_rise
);

  logic [TW-1:0] cmp_q;
  logic [TW-1:0] cnt_arr [NTMR];
  logic [TW-1:0] cnt_sel;
  logic          match_now;
  logic          match_q;

  for (genvar g = 0; g < NTMR; g++) begin : g_split
    assign cnt_arr[g] = tmr_cnt[g*TW +: TW];
  end

  assign cnt_sel    = cnt_arr[tmr_sel];
  assign match_now  = (cmp_q == cnt_sel);
  assign match_rise = match_now && !match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      match_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      match_q <= match_now;
    end
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    match_rise |=> !match_rise); // R10

  AST_HELD_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (match_now && !cmp_we && $stable(tmr_sel)) |=> ($stable(cnt_sel) -> !match_rise)); // R10

endmodule

// File: rtl/ocmp_action.sv
module ocmp_action
  import ocmp_pkg::*;
#(
  parameter int NTMR = 2,
  localparam int SW  = $clog2(NTMR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              match_rise,
  input  logic [SW-1:0]     tmr_sel,
  input  logic              adc_en,
  input  logic              irq_clr,
  output logic              latch_q,
  output logic              irq_q,
  output logic [NTMR-1:0]   tmr_rst,
  output logic              adc_start
);

  logic [MODE_W-1:0] mode_q;
  logic              fire;
  logic              evt_fire;
  logic              latch_d;

  assign fire     = match_rise && mode_active(mode_q);
  assign evt_fire = fire && (mode_q == M_EVT);

  always_comb begin
    latch_d = latch_q;
    if (fire) begin
      case (mode_q)
        M_SET:    latch_d = 1'b1;
        M_CLR:    latch_d = 1'b0;
        M_TOGGLE: latch_d = !latch_q;
        default:  latch_d = latch_q;
      endcase
    end
    if (mode_we && (mode_wdata == M_OFF)) latch_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_OFF;
      latch_q   <= 1'b0;
      irq_q     <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      latch_q <= latch_d;
      if (fire)         irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      adc_start <= evt_fire && adc_en;
    end
  end

  for (genvar g = 0; g < NTMR; g++) begin : g_rst
    always_ff @(posedge clk) begin
      if (!rst_n) tmr_rst[g] <= 1'b0;
      else        tmr_rst[g] <= evt_fire && (tmr_sel == SW'(g));
    end
  end

  AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && (mode_wdata == M_OFF)) |=> !latch_q); // R11

  AST_SWI_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SWI && !mode_we) |=> $stable(latch_q)); // R6

  AST_EVT_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_EVT && !mode_we) |=> $stable(latch_q)); // R8

  AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_rst)); // R8

  AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_rst) |=> !(|tmr_rst)); // R8

  AST_ADC_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (|tmr_rst)); // R9

  AST_IRQ_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_rst) |-> irq_q); // R7

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int TW   = 16,
  parameter int NTMR = 2,
  localparam int SW  = $clog2(NTMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_we,
  input  logic [TW-1:0]      cmp_wdata,
  input  logic               mode_we,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic [SW-1:0]      tmr_sel,
  input  logic [NTMR*TW-1:0] tmr_cnt,
  input  logic               adc_en,
  input  logic               irq_clr,
  input  logic               pin_dir,
  output logic [NTMR-1:0]    tmr_rst,
  output logic               adc_start,
  output logic               irq_flag,
  output logic               pin_out,
  output logic               pin_oe
);

  logic match_rise;
  logic latch_q;

  ocmp_detect #(.TW(TW), .NTMR(NTMR)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_we     (cmp_we),
    .cmp_wdata  (cmp_wdata),
    .tmr_sel    (tmr_sel),
    .tmr_cnt    (tmr_cnt),
    .match_rise (match_rise)
  );

  ocmp_action #(.NTMR(NTMR)) u_action (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .match_rise (match_rise),
    .tmr_sel    (tmr_sel),
    .adc_en     (adc_en),
    .irq_clr    (irq_clr),
    .latch_q    (latch_q),
    .irq_q      (irq_flag),
    .tmr_rst    (tmr_rst),
    .adc_start  (adc_start)
  );

  assign pin_oe  = pin_dir;
  assign pin_out = pin_dir && latch_q;

  AST_PIN_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out); // R12

endmodule

// File: tb/ocmp_channel_bench.sv
module ocmp_channel_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CV = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_we = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        mode_we = 1'b0;
  logic [3:0]  mode_wdata = '0;
  logic [0:0]  tmr_sel = '0;
  logic [31:0] tmr_cnt = 32'hFFFF_FFFF;
  logic        adc_en = 1'b0;
  logic        irq_clr = 1'b0;
  logic        pin_dir = 1'b1;
  logic [1:0]  tmr_rst;
  logic        adc_start, irq_flag, pin_out, pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] e_cmp = '0;
  logic [3:0]  e_mode = '0;
  logic        e_prev = 1'b0;
  logic        e_latch = 1'b0;
  logic        e_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  ocmp_channel u_ocmp_channel (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .tmr_sel(tmr_sel),
    .tmr_cnt(tmr_cnt), .adc_en(adc_en), .irq_clr(irq_clr), .pin_dir(pin_dir),
    .tmr_rst(tmr_rst), .adc_start(adc_start), .irq_flag(irq_flag),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic string pin_tag(input logic [3:0] m);
    case (m)
      4'b1000: pin_tag = "R3 pin";
      4'b1001: pin_tag = "R4 pin";
      4'b0010: pin_tag = "R5 pin";
      4'b1010: pin_tag = "R6 pin";
      4'b1011: pin_tag = "R8 pin";
      default: pin_tag = "R12 pin";
    endcase
  endfunction

  function automatic logic is_active(input logic [3:0] m);
    is_active = (m == 4'b1000) || (m == 4'b1001) || (m == 4'b0010) ||
                (m == 4'b1010) || (m == 4'b1011);
  endfunction

  // One cycle: drive at falling edge, model the next state, sample after the rising edge.
  task automatic drive(input logic vwe, input logic [15:0] vd, input logic mwe,
                       input logic [3:0] md, input logic sel, input logic [15:0] ta,
                       input logic [15:0] tb, input logic aen, input logic clr,
                       input logic dir, input string note);
    logic m, evt, nl, ni, trg;
    logic [1:0] e_rst;
    @(negedge clk);
    cmp_we = vwe; cmp_wdata = vd; mode_we = mwe; mode_wdata = md;
    tmr_sel = sel; tmr_cnt = {tb, ta}; adc_en = aen; irq_clr = clr; pin_dir = dir;
    m   = (e_cmp == (sel ? tb : ta));
    evt = m && !e_prev && is_active(e_mode);
    nl  = e_latch;
    if (evt) begin
      if (e_mode == 4'b1000) nl = 1'b1;
      else if (e_mode == 4'b1001) nl = 1'b0;
      else if (e_mode == 4'b0010) nl = !e_latch;
    end
    if (mwe && md == 4'b0000) nl = 1'b0;
    ni = e_irq;
    if (clr) ni = 1'b0;
    if (evt) ni = 1'b1;
    trg   = evt && (e_mode == 4'b1011);
    e_rst = {trg && sel, trg && !sel};
    @(posedge clk);
    #1;
    chk({pin_tag(e_mode), " ", note}, {31'd0, pin_out}, {31'd0, dir && nl});
    chk({"R12 oe ", note}, {31'd0, pin_oe}, {31'd0, dir});
    chk({"R7 irq ", note}, {31'd0, irq_flag}, {31'd0, ni});
    chk({"R8 tmr_rst ", note}, {30'd0, tmr_rst}, {30'd0, e_rst});
    chk({"R9 adc ", note}, {31'd0, adc_start}, {31'd0, trg && aen});
    e_prev = m; e_latch = nl; e_irq = ni;
    if (vwe) e_cmp = vd;
    if (mwe) e_mode = md;
  endtask

  task automatic step(input logic sel, input logic [15:0] sv, input logic aen,
                      input logic clr, input logic dir, input string note);
    drive(1'b0, '0, 1'b0, '0, sel, sel ? CV : sv, sel ? sv : CV, aen, clr, dir, note);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pin", {31'd0, pin_out}, 32'd0);
    chk("R1 irq", {31'd0, irq_flag}, 32'd0);
    chk("R1 tmr_rst", {30'd0, tmr_rst}, 32'd0);
    chk("R1 adc", {31'd0, adc_start}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep every action code, both timers, converter enable on and off.
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < 2; a++) begin
          drive(1'b1, CV, 1'b1, 4'(m), 1'(s), ~CV, ~CV, 1'(a), 1'b0, 1'b1, "setup");
          step(1'(s), CV ^ 16'h0001, 1'(a), 1'b0, 1'b1, "R2 lsb differs");
          step(1'(s), CV ^ 16'h8000, 1'(a), 1'b0, 1'b0, "R2 msb differs");
          step(1'(s), CV,            1'(a), 1'b0, 1'b1, "R2 match");
          step(1'(s), CV,            1'(a), 1'b0, 1'b1, "R10 held");
          step(1'(s), CV,            1'(a), 1'b1, 1'b1, "R10 held clear");
          step(1'(s), CV ^ 16'h0400, 1'(a), 1'b0, 1'b1, "R2 mid differs");
          step(1'(s), CV,            1'(a), 1'b1, 1'b1, "R7 set beats clear");
          step(1'(s), CV,            1'(a), 1'b0, 1'b0, "R12 dir low");
          step(1'(s), ~CV,           1'(a), 1'b1, 1'b1, "R7 clear");
        end
      end
    end

    // R2: new compare value takes effect one cycle after its write.
    drive(1'b1, 16'h0001, 1'b1, 4'b0010, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b1, "R2 write");
    drive(1'b0, '0, 1'b0, '0, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b1, "R2 new value");
    // R11: latch set high, then an off-code write pulls it low.
    drive(1'b0, '0, 1'b1, 4'b1000, 1'b1, 16'h0000, 16'h0007, 1'b0, 1'b0, 1'b1, "R11 prep");
    drive(1'b0, '0, 1'b0, '0, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1, "R11 set");
    drive(1'b0, '0, 1'b1, 4'b0000, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1, "R11 off write");
    // R11: off write on the same cycle as a set event still leaves the latch low.
    drive(1'b0, '0, 1'b1, 4'b1000, 1'b1, 16'h0000, 16'h0005, 1'b0, 1'b1, 1'b1, "R11 prep2");
    drive(1'b0, '0, 1'b1, 4'b0000, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1, "R11 off with event");
    drive(1'b0, '0, 1'b0, '0, 1'b1, 16'h0000, 16'h0002, 1'b0, 1'b0, 1'b1, "R11 after");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule